// File: doc/BRIEF.md
# Coherent Clock Snapshot Reader

This block is a small bus master that sits in front of a battery-backed calendar clock core reached through an indexed register port. On a capture request it takes one self-consistent snapshot of the calendar. It first waits until the core's update-busy flag reads clear. It then fetches the seven time fields and the mode byte. Last, it fetches the seconds again, and if the seconds have moved it throws the snapshot away and starts over.

An accepted snapshot is turned into plain binary fields and held on registered outputs. This covers BCD decoding, afternoon-flag folding into a 24-hour value, zero-based month and weekday, and a year counted from 1900 through a two-digit window.

A second request type aligns software to the clock's tick. The block waits for the update-busy flag to go high and then low again. Each wait is bounded by a poll limit that is counted in bus reads, and running out of polls is reported as an error.

Every bus read is a one-cycle `rd_en` pulse with `rd_idx`. The core returns the byte on `rd_data` in the following cycle.

Top module: `rtc_snap_reader`

## Requirements
- R1: After reset `rd_en`, `done`, `err` and `valid` are all low, and no bus read is issued until a request arrives.
- R2: A capture first reads index 10. The capture leaves this poll and reads a time field only after a poll returns bit 7 = 0; while bit 7 = 1 it keeps re-reading index 10.
- R3: Once the flag is clear, the block reads indexes 0, 2, 4, 6, 7, 8, 9 and 11 in that order, and then reads index 0 once more. Each read is two cycles after the one before it.
- R4: If the second read of index 0 differs from the first, no result is published and the capture restarts at the index 10 poll.
- R5: When bit 2 of the index 11 byte is 0, every field is BCD-decoded as low nibble + 10 × high nibble. When that bit is 1, the bytes pass through as binary.
- R6: In BCD mode, bit 7 of the hour byte (index 4) is a PM flag. It is removed before decoding, and when it is set 12 is added to the hour, with a sum of 24 becoming 0. In binary mode the hour byte is used whole.
- R7: The weekday (index 6) and month (index 8) outputs are the decoded values minus one.
- R8: A decoded year (index 9) below 69 is output plus 100, and any other year is output unchanged.
- R9: A good capture gives a one-cycle `done` with `err` low and sets `valid`. The fields hold until the next good capture, and `valid` goes low when a new capture is accepted.
- R10: A sync request polls index 10 until bit 7 rises and then until it falls. It finishes with `done` and `err` low, and leaves `valid` and the fields unchanged.
- R11: If RISE_LIM consecutive sync polls read bit 7 = 0, the sync ends with `done` and `err` high. RISE_LIM − 1 low reads followed by a high read do not fail.
- R12: If, after the rise, FALL_LIM consecutive polls read bit 7 = 1, the sync ends with `done` and `err` high.
- R13: Requests that arrive while an operation runs are ignored. When `start` and `sync` are both high, the capture is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture request, sampled while idle |
| sync | input | 1 | Tick-alignment request, sampled while idle |
| rd_en | output | 1 | Bus read strobe |
| rd_idx | output | 7 | Register index for the read |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, high only with `done` |
| valid | output | 1 | Held snapshot is good |
| sec_o | output | 8 | Seconds, binary |
| min_o | output | 8 | Minutes, binary |
| hour_o | output | 8 | Hour, 0 to 23 |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month, zero-based |
| year_o | output | 8 | Years since 1900 |
| wday_o | output | 8 | Weekday, zero-based |

## Verification
The bench builds the block with RISE_LIM = 8 and FALL_LIM = 4, in place of the defaults of ten million and one million. With these values both timeout paths can be reached in a few dozen cycles, and so can the exact boundary of RISE_LIM − 1 low polls followed by a rise. The bench's core model counts every bus read and can bump the seconds after the first seconds read. This makes the number of restarts and polls directly observable, so it can be compared with the counts the requirements imply.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int IDX_W   = 7;
  localparam int BYTE_W  = 8;
  localparam int NFLD    = 7;          // time fields captured
  localparam int NSTEP   = NFLD + 1;   // plus the mode byte
  localparam int STEP_W  = $clog2(NSTEP);
  localparam logic [IDX_W-1:0] IDX_FLAG = 7'd10;
  localparam logic [IDX_W-1:0] IDX_SEC  = 7'd0;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FLAG_RD, ST_FLAG_CHK, ST_FLD_RD, ST_FLD_CAP,
    ST_SEC_RD, ST_SEC_CHK, ST_RISE_RD, ST_RISE_CHK, ST_FALL_RD, ST_FALL_CHK
  } snap_state_e;

  // bus index for each capture step; order is part of the behaviour
  function automatic logic [IDX_W-1:0] step_index(logic [STEP_W-1:0] s);
    case (s)
      3'd0:    return 7'd0;
      3'd1:    return 7'd2;
      3'd2:    return 7'd4;
      3'd3:    return 7'd6;
      3'd4:    return 7'd7;
      3'd5:    return 7'd8;
      3'd6:    return 7'd9;
      default: return 7'd11;
    endcase
  endfunction
endpackage

// File: rtl/snap_rst_sync.sv
module snap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/snap_poll_ctr.sv
module snap_poll_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/snap_bcd2bin.sv
module snap_bcd2bin
  import snap_pkg::*;
(
  input  byte_t din,
  output byte_t dout
);
  byte_t tens;
  always_comb begin
    tens = byte_t'(din[7:4]) * byte_t'(10);
    dout = tens + byte_t'(din[3:0]);
  end
endmodule

// File: rtl/snap_normalize.sv
module snap_normalize
  import snap_pkg::*;
(
  input  logic [NFLD-1:0][BYTE_W-1:0] raw,      // sec,min,hour,wday,mday,mon,year
  input  logic                        bin_mode,
  output byte_t                       sec_n,
  output byte_t                       min_n,
  output byte_t                       hour_n,
  output byte_t                       wday_n,
  output byte_t                       mday_n,
  output byte_t                       mon_n,
  output byte_t                       year_n
);
  localparam int F_HOUR = 2;
  localparam byte_t YEAR_PIVOT = 8'd69;

  byte_t dec   [NFLD];
  byte_t chose [NFLD];
  logic  pm;
  byte_t h_pm;

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    byte_t src;
    if (i == F_HOUR) begin : g_hr
      assign src = {1'b0, raw[i][6:0]};
    end else begin : g_plain
      assign src = raw[i];
    end
    snap_bcd2bin u_dec (.din(src), .dout(dec[i]));
    assign chose[i] = bin_mode ? raw[i] : dec[i];
  end

  always_comb begin
    pm     = !bin_mode && raw[F_HOUR][7];
    h_pm   = chose[F_HOUR] + 8'd12;
    sec_n  = chose[0];
    min_n  = chose[1];
    hour_n = pm ? ((h_pm == 8'd24) ? 8'd0 : h_pm) : chose[F_HOUR];
    wday_n = chose[3] - 8'd1;
    mday_n = chose[4];
    mon_n  = chose[5] - 8'd1;
    year_n = (chose[6] < YEAR_PIVOT) ? chose[6] + 8'd100 : chose[6];
  end
endmodule

// File: rtl/rtc_snap_reader.sv
module rtc_snap_reader
  import snap_pkg::*;
#(
  parameter int RISE_LIM = 10_000_000,
  parameter int FALL_LIM = 1_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sync,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [7:0]       rd_data,
  output logic             done,
  output logic             err,
  output logic             valid,
  output logic [7:0]       sec_o,
  output logic [7:0]       min_o,
  output logic [7:0]       hour_o,
  output logic [7:0]       mday_o,
  output logic [7:0]       mon_o,
  output logic [7:0]       year_o,
  output logic [7:0]       wday_o
);
  localparam int LIM_MAX = (RISE_LIM > FALL_LIM) ? RISE_LIM : FALL_LIM;
  localparam int CW      = $clog2(LIM_MAX + 1);
  localparam logic [CW-1:0] RISE_LAST = CW'(RISE_LIM - 1);
  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_LIM - 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NSTEP - 1);

  logic rst_i_n;
  snap_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  snap_state_e st, st_n;
  logic [STEP_W-1:0] step, step_n;
  logic [NFLD-1:0][BYTE_W-1:0] raw_q;
  logic bin_q;
  logic cnt_clr, cnt_inc;
  logic [CW-1:0] cnt;
  logic ld_raw, ld_out, done_n, err_n, valid_set, valid_clr;
  byte_t n_sec, n_min, n_hour, n_wday, n_mday, n_mon, n_year;

  snap_poll_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_i_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  snap_normalize u_norm (
    .raw(raw_q), .bin_mode(bin_q),
    .sec_n(n_sec), .min_n(n_min), .hour_n(n_hour), .wday_n(n_wday),
    .mday_n(n_mday), .mon_n(n_mon), .year_n(n_year)
  );

  // next-state and bus control
  always_comb begin
    st_n      = st;
    step_n    = step;
    rd_en     = 1'b0;
    rd_idx    = '0;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    ld_raw    = 1'b0;
    ld_out    = 1'b0;
    done_n    = 1'b0;
    err_n     = 1'b0;
    valid_set = 1'b0;
    valid_clr = 1'b0;
    case (st)
      ST_IDLE: begin
        if (start) begin
          valid_clr = 1'b1;
          st_n      = ST_FLAG_RD;
        end else if (sync) begin
          cnt_clr = 1'b1;
          st_n    = ST_RISE_RD;
        end
      end
      ST_FLAG_RD: begin
        rd_en  = 1'b1;
        rd_idx = IDX_FLAG;
        st_n   = ST_FLAG_CHK;
      end
      ST_FLAG_CHK: begin
        if (rd_data[7]) st_n = ST_FLAG_RD;
        else begin
          step_n = '0;
          st_n   = ST_FLD_RD;
        end
      end
      ST_FLD_RD: begin
        rd_en  = 1'b1;
        rd_idx = step_index(step);
        st_n   = ST_FLD_CAP;
      end
      ST_FLD_CAP: begin
        ld_raw = 1'b1;
        if (step == STEP_LAST) st_n = ST_SEC_RD;
        else begin
          step_n = step + 1'b1;
          st_n   = ST_FLD_RD;
        end
      end
      ST_SEC_RD: begin
        rd_en  = 1'b1;
        rd_idx = IDX_SEC;
        st_n   = ST_SEC_CHK;
      end
      ST_SEC_CHK: begin
        if (rd_data == raw_q[0]) begin
          ld_out    = 1'b1;
          done_n    = 1'b1;
          valid_set = 1'b1;
          st_n      = ST_IDLE;
        end else begin
          st_n = ST_FLAG_RD;
        end
      end
      ST_RISE_RD: begin
        rd_en  = 1'b1;
        rd_idx = IDX_FLAG;
        st_n   = ST_RISE_CHK;
      end
      ST_RISE_CHK: begin
        if (rd_data[7]) begin
          cnt_clr = 1'b1;
          st_n    = ST_FALL_RD;
        end else if (cnt == RISE_LAST) begin
          done_n = 1'b1;
          err_n  = 1'b1;
          st_n   = ST_IDLE;
        end else begin
          cnt_inc = 1'b1;
          st_n    = ST_RISE_RD;
        end
      end
      ST_FALL_RD: begin
        rd_en  = 1'b1;
        rd_idx = IDX_FLAG;
        st_n   = ST_FALL_CHK;
      end
      ST_FALL_CHK: begin
        if (!rd_data[7]) begin
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end else if (cnt == FALL_LAST) begin
          done_n = 1'b1;
          err_n  = 1'b1;
          st_n   = ST_IDLE;
        end else begin
          cnt_inc = 1'b1;
          st_n    = ST_FALL_RD;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st    <= ST_IDLE;
      step  <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
      valid <= 1'b0;
    end else begin
      st   <= st_n;
      step <= step_n;
      done <= done_n;
      err  <= err_n;
      if (valid_clr)      valid <= 1'b0;
      else if (valid_set) valid <= 1'b1;
    end
  end

  // raw capture registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      raw_q <= '0;
      bin_q <= 1'b0;
    end else if (ld_raw) begin
      if (step == STEP_LAST) bin_q <= rd_data[2];
      else                   raw_q[step] <= rd_data;
    end
  end

  // published fields
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sec_o  <= '0;
      min_o  <= '0;
      hour_o <= '0;
      mday_o <= '0;
      mon_o  <= '0;
      year_o <= '0;
      wday_o <= '0;
    end else if (ld_out) begin
      sec_o  <= n_sec;
      min_o  <= n_min;
      hour_o <= n_hour;
      mday_o <= n_mday;
      mon_o  <= n_mon;
      year_o <= n_year;
      wday_o <= n_wday;
    end
  end
endmodule

// File: rtl/snap_reader_chk.sv
module snap_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [6:0] rd_idx,
  input logic [7:0] rd_data,
  input logic       done,
  input logic       err,
  input logic       valid
);
  // R2: a read of index 0 right after a flag poll needs a clear flag
  assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == 7'd0 && $past(rd_en, 2) && $past(rd_idx, 2) == 7'd10)
      |-> !$past(rd_data[7], 1));

  // R3: minutes follow seconds, mode byte follows year
  assert_order_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == 7'd2) |-> ($past(rd_en, 2) && $past(rd_idx, 2) == 7'd0));

  assert_order_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == 7'd11) |-> ($past(rd_en, 2) && $past(rd_idx, 2) == 7'd9));

  // R9: done is a single-cycle pulse and no read is issued in the next cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !rd_en));

  assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> (done && !err));

  // R11/R12: error only with completion; R10: sync leaves valid alone
  assert_err_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_sync_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> $stable(valid));
endmodule

bind rtc_snap_reader snap_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
  .rd_data(rd_data), .done(done), .err(err), .valid(valid)
);

// File: tb/sim_rtc_snap_reader.sv
module sim_rtc_snap_reader;
  localparam int RL = 8;
  localparam int FL = 4;

  logic clk, rst_n, start, sync, rd_en, done, err, valid;
  logic [6:0] rd_idx;
  logic [7:0] rd_data, sec_o, min_o, hour_o, mday_o, mon_o, year_o, wday_o;

  rtc_snap_reader #(.RISE_LIM(RL), .FALL_LIM(FL)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sync(sync),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .done(done), .err(err), .valid(valid),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .mday_o(mday_o),
    .mon_o(mon_o), .year_o(year_o), .wday_o(wday_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int fails = 0;

  // clock core model
  logic [7:0] regs [128];
  int pre_lo, hi_n, n10, n0, nlog;
  bit bump_on;
  int idx_log [64];

  function automatic logic flag_at(int n);
    return (n >= pre_lo) && (n < pre_lo + hi_n);
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      if (nlog < 64) idx_log[nlog] = int'(rd_idx);
      nlog = nlog + 1;
      if (rd_idx == 7'd10) begin
        rd_data <= {flag_at(n10), 7'h26};
        n10 = n10 + 1;
      end else begin
        rd_data <= regs[rd_idx];
      end
      if (rd_idx == 7'd0) begin
        if (bump_on && n0 == 0) regs[0] = regs[0] + 8'd1;
        n0 = n0 + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_model(input int lo, input int hi);
    pre_lo = lo; hi_n = hi; n10 = 0; n0 = 0; nlog = 0; bump_on = 0;
  endtask

  task automatic pulse(input bit s, input bit y);
    @(negedge clk);
    start = s; sync = y;
    @(negedge clk);
    start = 0; sync = 0;
  endtask

  task automatic wait_done(input string tag);
    int c = 0;
    while (!done && c < 3000) begin
      @(negedge clk);
      c++;
    end
    chk(done == 1'b1, tag, int'(done), 1);
  endtask

  task automatic load_time(input logic [7:0] s, mi, h, wd, md, mo, y, mode);
    regs[0] = s; regs[2] = mi; regs[4] = h; regs[6] = wd;
    regs[7] = md; regs[8] = mo; regs[9] = y; regs[11] = mode;
  endtask

  task automatic t_reset();
    chk(rd_en == 0, "R1 rd_en", int'(rd_en), 0);
    chk(done == 0 && err == 0, "R1 done/err", int'({done, err}), 0);
    chk(valid == 0, "R1 valid", int'(valid), 0);
    chk(nlog == 0, "R1 no reads", nlog, 0);
  endtask

  task automatic t_bcd();
    int exp_seq [12] = '{10, 10, 10, 0, 2, 4, 6, 7, 8, 9, 11, 0};
    load_time(8'h45, 8'h30, 8'h91, 8'h03, 8'h15, 8'h12, 8'h24, 8'h02);
    clear_model(0, 2);
    pulse(1, 0);
    wait_done("R9 bcd done");
    chk(err == 0, "R9 no err", int'(err), 0);
    chk(n10 == 3, "R2 flag polls", n10, 3);
    chk(nlog == 12, "R3 read count", nlog, 12);
    for (int i = 0; i < 12; i++)
      chk(idx_log[i] == exp_seq[i], "R3 order", idx_log[i], exp_seq[i]);
    chk(sec_o == 45 && min_o == 30, "R5 sec/min", int'(sec_o), 45);
    chk(mday_o == 15, "R5 mday", int'(mday_o), 15);
    chk(hour_o == 23, "R6 pm hour", int'(hour_o), 23);
    chk(wday_o == 2, "R7 wday", int'(wday_o), 2);
    chk(mon_o == 11, "R7 mon", int'(mon_o), 11);
    chk(year_o == 124, "R8 year", int'(year_o), 124);
    @(negedge clk);
    chk(valid == 1, "R9 valid held", int'(valid), 1);
  endtask

  task automatic t_pm12();
    load_time(8'h00, 8'h00, 8'h92, 8'h01, 8'h01, 8'h01, 8'h69, 8'h00);
    clear_model(0, 0);
    pulse(1, 0);
    wait_done("R6 pm12 done");
    chk(hour_o == 0, "R6 pm 12 wraps", int'(hour_o), 0);
    chk(year_o == 69, "R8 year 69", int'(year_o), 69);
    load_time(8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h68, 8'h00);
    clear_model(0, 0);
    pulse(1, 0);
    wait_done("R6 am12 done");
    chk(hour_o == 12, "R6 no pm", int'(hour_o), 12);
    chk(year_o == 168, "R8 year 68", int'(year_o), 168);
  endtask

  task automatic t_bin();
    load_time(8'd59, 8'd7, 8'd17, 8'd1, 8'd31, 8'd1, 8'd5, 8'h04);
    clear_model(0, 3);
    pulse(1, 0);
    @(negedge clk);
    chk(valid == 0, "R9 valid cleared", int'(valid), 0);
    wait_done("R5 bin done");
    chk(sec_o == 59 && min_o == 7, "R5 binary pass", int'(sec_o), 59);
    chk(hour_o == 17, "R6 binary hour", int'(hour_o), 17);
    chk(mday_o == 31, "R5 mday", int'(mday_o), 31);
    chk(mon_o == 0 && wday_o == 0, "R7 zero based", int'(mon_o), 0);
    chk(year_o == 105, "R8 binary year", int'(year_o), 105);
    chk(valid == 1, "R9 valid set", int'(valid), 1);
  endtask

  task automatic t_retry();
    load_time(8'h10, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h70, 8'h00);
    clear_model(0, 0);
    bump_on = 1;
    pulse(1, 0);
    wait_done("R4 retry done");
    chk(n0 == 4, "R4 sec reads", n0, 4);
    chk(n10 == 2, "R4 restart polls", n10, 2);
    chk(sec_o == 11, "R4 new seconds", int'(sec_o), 11);
  endtask

  task automatic t_sync_ok();
    logic [7:0] hsave;
    hsave = hour_o;
    clear_model(3, 2);
    pulse(0, 1);
    wait_done("R10 sync done");
    chk(err == 0, "R10 no err", int'(err), 0);
    chk(n10 == 6, "R10 poll count", n10, 6);
    chk(nlog == 6, "R10 flag only", nlog, 6);
    chk(valid == 1 && hour_o == hsave, "R10 fields kept", int'(hour_o), int'(hsave));
  endtask

  task automatic t_rise_to();
    clear_model(1000, 0);
    pulse(0, 1);
    wait_done("R11 rise done");
    chk(err == 1, "R11 rise timeout", int'(err), 1);
    chk(n10 == RL, "R11 poll count", n10, RL);
    clear_model(RL - 1, 2);
    pulse(0, 1);
    wait_done("R11 edge done");
    chk(err == 0, "R11 edge ok", int'(err), 0);
    chk(n10 == RL + 2, "R11 edge polls", n10, RL + 2);
  endtask

  task automatic t_fall_to();
    clear_model(0, 1000);
    pulse(0, 1);
    wait_done("R12 fall done");
    chk(err == 1, "R12 fall timeout", int'(err), 1);
    chk(n10 == FL + 1, "R12 poll count", n10, FL + 1);
  endtask

  task automatic t_busy();
    int extra = 0;
    load_time(8'h05, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h70, 8'h00);
    clear_model(0, 20);
    pulse(1, 0);
    repeat (5) @(negedge clk);
    pulse(0, 1);
    wait_done("R13 busy done");
    chk(n10 == 21, "R13 no extra polls", n10, 21);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (rd_en) extra++;
    end
    chk(extra == 0, "R13 sync ignored", extra, 0);
    clear_model(0, 0);
    pulse(1, 1);
    wait_done("R13 both done");
    chk(n0 == 2 && err == 0, "R13 start wins", n0, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) regs[i] = 8'h00;
    clear_model(0, 0);
    rd_data = 8'h00;
    rst_n = 0; start = 0; sync = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bcd();
    t_pm12();
    t_bin();
    t_retry();
    t_sync_ok();
    t_rise_to();
    t_fall_to();
    t_busy();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule